// File: doc/BRIEF.md
# Elastic-Buffer Gapped Clock Enable Generator

This block turns a fixed, free-running base clock into a gapped read clock for an elastic FIFO. It does not gate the clock itself. It produces a per-cycle enable (`gclk_en`) that is low for exactly one whole base cycle out of every N. A source that runs plesiochronously to the base clock fills the FIFO. The block watches the FIFO's fill-level flags and moves the gap interval N one step at a time, so that the long-term read rate follows the write rate. For example, a 100 MHz base with N = 100 gives an average of 99 MHz and a 1 MHz gap rate. The base clock must be faster than the payload source so that there is enough margin for the worst-case mutual drift.

A small state machine runs the gap counter. It has two states. `S_PASS` is a passing cycle with the enable high. `S_GAP` is the single suppressed cycle with the enable low. The transition `S_PASS -> S_GAP` happens when the count reaches N. The transition `S_GAP -> S_PASS` always happens on the next cycle, and it reloads the count to 1.

The interval controller makes a decision on every wrap (the `S_GAP` cycle), choosing one of three actions:
- `ADJ_SHORT`: shorten N, so gaps come more often, because the FIFO is nearly empty.
- `ADJ_LONG`: lengthen N, so gaps come less often, because the FIFO is nearly full.
- `ADJ_HOLD`: leave N unchanged.

Each real change of N is one justification event and is signalled on `just_strobe`. An underrun or overrun sets a sticky error flag. The configured limits must satisfy 2 <= `cfg_n_min` <= `cfg_n_nom` <= `cfg_n_max`.

Top module: `gapclk_gen`

## Requirements
- R1: While reset is low, the outputs are `gclk_en`=1, `just_strobe`=0 and `slip_err`=0. N is loaded from `cfg_n_nom`, and the count starts at 1, so the first cycle after reset is enabled.
- R2: With N fixed, `gclk_en` is low in exactly one cycle of every N: the cycle where the count equals N. This gives N-1 enabled cycles and then one gap, repeating.
- R3: `gclk_en` is driven only from registers. A change on any FIFO flag input between clock edges does not change `gclk_en` before the next rising edge.
- R4: If `fifo_almost_empty`=1 and `fifo_almost_full`=0 in the gap cycle, the next interval is N-1, clamped so it is never below `cfg_n_min`.
- R5: If `fifo_almost_full`=1 and `fifo_almost_empty`=0 in the gap cycle, the next interval is N+1, clamped so it never exceeds `cfg_n_max`.
- R6: If both almost flags are 0 in the gap cycle, or both are 1, N is unchanged (hysteresis band).
- R7: N is updated only at the wrap. The flag values present in cycles other than the gap cycle have no effect on the gap pattern.
- R8: `just_strobe` is high for exactly the one cycle after a wrap in which N actually changed, which is the first cycle of the new interval. It stays low when a step is clamped to the same value.
- R9: An underrun or overrun input sampled high sets `slip_err` from the next cycle on. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_n_min | input | NW | Smallest allowed gap interval (>= 2) |
| cfg_n_max | input | NW | Largest allowed gap interval |
| cfg_n_nom | input | NW | Interval loaded at reset |
| fifo_almost_empty | input | 1 | FIFO fill is low |
| fifo_almost_full | input | 1 | FIFO fill is high |
| fifo_underrun | input | 1 | FIFO read while empty |
| fifo_overrun | input | 1 | FIFO written while full |
| gclk_en | output | 1 | Read clock enable, low in the gap cycle |
| just_strobe | output | 1 | One-cycle pulse per change of N |
| slip_err | output | 1 | Sticky underrun/overrun flag |

## Verification
An interval update, its justification strobe and the setting of the sticky error can all arise from the same gap-cycle edge. The bench provokes this overlap in two ways. It holds an almost flag while pulsing underrun or overrun, and it toggles the flags pseudo-randomly so that they change on gap cycles and between them. A cycle-level model in the bench judges every cycle of `gclk_en`, `just_strobe` and `slip_err`. Clamping at both limits is judged the same way, including a configuration whose minimum and maximum are equal.

// File: rtl/gapclk_pkg.sv
package gapclk_pkg;

    typedef enum logic [0:0] {
        S_PASS = 1'b0,
        S_GAP  = 1'b1
    } gap_state_t;

    typedef enum logic [1:0] {
        ADJ_HOLD  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } adj_t;

endpackage

// File: rtl/gapclk_counter.sv
module gapclk_counter
    import gapclk_pkg::*;
#(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] n_cur,
    output logic          wrap,
    output logic          en
);

    gap_state_t    state_q, state_d;
    logic [NW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_PASS;
            cnt_q   <= NW'(1);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_PASS: begin
                cnt_d = cnt_q + NW'(1);
                if ((cnt_q + NW'(1)) >= n_cur) state_d = S_GAP;
            end
            S_GAP: begin
                cnt_d   = NW'(1);
                state_d = S_PASS;
            end
        endcase
    end

    always_comb begin
        en   = 1'b1;
        wrap = 1'b0;
        unique case (state_q)
            S_PASS: en = 1'b1;
            S_GAP: begin
                en   = 1'b0;
                wrap = 1'b1;
            end
        endcase
    end

    AST_GAP_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP) |=> (state_q == S_PASS)); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= NW'(1)) && (cnt_q <= n_cur)); // R2

endmodule

// File: rtl/gapclk_interval.sv
module gapclk_interval
    import gapclk_pkg::*;
#(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] cfg_n_min,
    input  logic [NW-1:0] cfg_n_max,
    input  logic [NW-1:0] cfg_n_nom,
    input  logic          wrap,
    input  logic          lvl_low,
    input  logic          lvl_high,
    output logic [NW-1:0] n_cur,
    output logic          just
);

    localparam int XW = NW + 1;

    adj_t          adj;
    logic [XW-1:0] n_step;
    logic [NW-1:0] n_next;

    function automatic logic [NW-1:0] clamp_n(input logic [XW-1:0] v,
                                              input logic [NW-1:0] lo,
                                              input logic [NW-1:0] hi);
        if (v < {1'b0, lo})      return lo;
        else if (v > {1'b0, hi}) return hi;
        else                     return v[NW-1:0];
    endfunction

    always_comb begin
        if (lvl_low && !lvl_high)      adj = ADJ_SHORT;
        else if (lvl_high && !lvl_low) adj = ADJ_LONG;
        else                           adj = ADJ_HOLD;
    end

    always_comb begin
        n_step = {1'b0, n_cur};
        unique case (adj)
            ADJ_SHORT: n_step = {1'b0, n_cur} - XW'(1);
            ADJ_LONG:  n_step = {1'b0, n_cur} + XW'(1);
            ADJ_HOLD:  n_step = {1'b0, n_cur};
            default:   n_step = {1'b0, n_cur};
        endcase
        n_next = (adj == ADJ_HOLD) ? n_cur : clamp_n(n_step, cfg_n_min, cfg_n_max);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_cur <= cfg_n_nom;
            just  <= 1'b0;
        end else begin
            just <= 1'b0;
            if (wrap) begin
                n_cur <= n_next;
                just  <= (n_next != n_cur);
            end
        end
    end

    AST_N_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(n_cur) |-> $past(wrap)); // R7
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        just |=> !just); // R8
    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        just |-> ($past(wrap) && (n_cur != $past(n_cur)))); // R8

endmodule

// File: rtl/gapclk_errlatch.sv
module gapclk_errlatch (
    input  logic clk,
    input  logic rst_n,
    input  logic under,
    input  logic over,
    output logic err
);

    always_ff @(posedge clk) begin
        if (!rst_n)             err <= 1'b0;
        else if (under || over) err <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> err); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(under) || $past(over))); // R9

endmodule

// File: rtl/gapclk_gen.sv
module gapclk_gen
    import gapclk_pkg::*;
#(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] cfg_n_min,
    input  logic [NW-1:0] cfg_n_max,
    input  logic [NW-1:0] cfg_n_nom,
    input  logic          fifo_almost_empty,
    input  logic          fifo_almost_full,
    input  logic          fifo_underrun,
    input  logic          fifo_overrun,
    output logic          gclk_en,
    output logic          just_strobe,
    output logic          slip_err
);

    logic [NW-1:0] n_cur;
    logic          wrap;

    gapclk_counter #(.NW(NW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .n_cur (n_cur),
        .wrap  (wrap),
        .en    (gclk_en)
    );

    gapclk_interval #(.NW(NW)) u_ivl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_n_min (cfg_n_min),
        .cfg_n_max (cfg_n_max),
        .cfg_n_nom (cfg_n_nom),
        .wrap      (wrap),
        .lvl_low   (fifo_almost_empty),
        .lvl_high  (fifo_almost_full),
        .n_cur     (n_cur),
        .just      (just_strobe)
    );

    gapclk_errlatch u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .under (fifo_underrun),
        .over  (fifo_overrun),
        .err   (slip_err)
    );

    AST_EN_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        just_strobe |-> gclk_en); // R8

endmodule

// File: tb/sim_gapclk_gen.sv
module sim_gapclk_gen;

    localparam int NW       = 8;
    localparam int CLK_HALF = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] cfg_n_min = 8'd2, cfg_n_max = 8'd9, cfg_n_nom = 8'd5;
    logic          ae = 1'b0, af = 1'b0, ur = 1'b0, ov = 1'b0;
    logic          gclk_en, just_strobe, slip_err;

    int    vectors = 0;
    int    misses  = 0;
    int    m_cnt, m_n, m_min, m_max;
    bit    m_just, m_err;
    string tag = "R1";

    always #(CLK_HALF) clk = ~clk;

    gapclk_gen #(.NW(NW)) u0 (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_n_min         (cfg_n_min),
        .cfg_n_max         (cfg_n_max),
        .cfg_n_nom         (cfg_n_nom),
        .fifo_almost_empty (ae),
        .fifo_almost_full  (af),
        .fifo_underrun     (ur),
        .fifo_overrun      (ov),
        .gclk_en           (gclk_en),
        .just_strobe       (just_strobe),
        .slip_err          (slip_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(tag,  "gclk_en",     int'(gclk_en),     int'(m_cnt != m_n));
        chk("R8", "just_strobe", int'(just_strobe), int'(m_just));
        chk("R9", "slip_err",    int'(slip_err),    int'(m_err));
    endtask

    // starts and ends at a falling edge
    task automatic step(input bit s_ae, input bit s_af, input bit s_ur, input bit s_ov);
        bit prev_en;
        int nn;
        compare_all();
        prev_en = gclk_en;
        ae = s_ae; af = s_af; ur = s_ur; ov = s_ov;
        #1;
        chk("R3", "gclk_en after input change", int'(gclk_en), int'(prev_en));
        @(posedge clk); #1;
        if (m_cnt == m_n) begin
            nn = m_n;
            if (s_ae && !s_af)      nn = (m_n - 1 < m_min) ? m_min : m_n - 1;
            else if (s_af && !s_ae) nn = (m_n + 1 > m_max) ? m_max : m_n + 1;
            m_just = (nn != m_n);
            m_n    = nn;
            m_cnt  = 1;
        end else begin
            m_cnt++;
            m_just = 1'b0;
        end
        if (s_ur || s_ov) m_err = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset(input int mn, input int mx, input int nom);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_n_min = NW'(mn); cfg_n_max = NW'(mx); cfg_n_nom = NW'(nom);
        ae = 0; af = 0; ur = 0; ov = 0;
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1", "gclk_en in reset", int'(gclk_en), 1);
        chk("R1", "just_strobe in reset", int'(just_strobe), 0);
        chk("R1", "slip_err in reset", int'(slip_err), 0);
        rst_n = 1'b1;
        m_cnt = 1; m_n = nom; m_min = mn; m_max = mx; m_just = 0; m_err = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        for (int c = 0; c < 3; c++) begin
            int mn, mx, nom;
            case (c)
                0: begin mn = 2; mx = 9; nom = 5; end
                1: begin mn = 3; mx = 3; nom = 3; end
                default: begin mn = 4; mx = 7; nom = 7; end
            endcase
            do_reset(mn, mx, nom);
            tag = "R1";
            for (int i = 0; i < nom; i++) step(0, 0, 0, 0);
            tag = "R2";
            for (int i = 0; i < 3 * nom; i++) step(0, 0, 0, 0);
            tag = "R4";
            for (int i = 0; i < 50; i++) step(1, 0, 0, 0);
            tag = "R6";
            for (int i = 0; i < 20; i++) step(0, 0, 0, 0);
            for (int i = 0; i < 20; i++) step(1, 1, 0, 0);
            tag = "R5";
            for (int i = 0; i < 80; i++) step(0, 1, 0, 0);
            tag = "R7";
            lfsr = 8'hA5 ^ 8'(c);
            for (int i = 0; i < 250; i++) begin
                step(lfsr[0], lfsr[3], 0, 0);
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            end
            tag = "R9";
            step(1, 0, 1, 0);
            for (int i = 0; i < 15; i++) step(0, 1, 0, 0);
            step(0, 1, 0, 1);
            for (int i = 0; i < 15; i++) step(1, 0, 0, 0);
            chk("R9", "slip_err held", int'(slip_err), 1);
        end
        do_reset(2, 9, 5);
        chk("R9", "slip_err cleared by reset", int'(slip_err), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule